// File: doc/BRIEF.md
# Code Space Bank Mapper with SRAM Overlay

This block sits between an instruction-fetch unit and the physical memories. It takes a 16-bit code address and decides where the byte lives. It drives the read port of the flash or of the SRAM, or it answers with a zero byte. One cycle later it returns the byte together with the chosen target and the physical address it used.

The low half of code space is fixed to the first 32 KB of flash. The high half shows a 32 KB flash bank picked by a bank-select input. When the overlay input is set, the first `SRAM_BYTES` bytes of the high half come from SRAM instead, so that code can run from RAM, and flash stays visible above that window.

A data-side requester shares the SRAM read port. The data side normally wins a collision. A fetch that loses is held for exactly one cycle through `fetch_ready` and wins on its retry.

Top module: `code_bank_mapper`

## Requirements
- R1: Any fetch with address bit 15 clear returns target code 0 (flash), with physical address equal to the 15-bit offset and upper bits zero. This holds whatever the bank-select and overlay values are.
- R2: With the overlay off, a fetch at 0x8000 or above with bank-select below `NUM_BANKS` returns target 0 (flash), physical address {bank, addr[14:0]}, and the flash byte stored there.
- R3: A high-half fetch that is not in the SRAM window returns target code 2 (zero), physical address 0 and data 0x00, and it raises no flash read. This happens when bank-select is at or above `NUM_BANKS`, or when `NUM_BANKS` is 1.
- R4: With the overlay on, fetches from 0x8000 to 0x8000+`SRAM_BYTES`-1 return target code 1 (SRAM), physical address addr-0x8000, and the SRAM byte at that offset.
- R5: With the overlay on, fetches from 0x8000+`SRAM_BYTES` to 0xFFFF still follow R2 or R3 for the selected bank.
- R6: After reset `fetch_valid` and `data_valid` are low and `fetch_ready` is high. The first fetch, at 0x0000, reads flash physical address 0 for any bank or overlay setting.
- R7: Bank-select and overlay are sampled in the cycle a fetch is accepted. Changing them in the following cycle leaves the returned target, address and data unchanged.
- R8: When a fetch to the SRAM window meets a data request, the data side is granted and `fetch_ready` drops. In the next cycle the held fetch is accepted and the data request waits, so a fetch never stalls more than one cycle.
- R9: `fetch_valid` is high exactly in the cycle after a fetch is accepted (`fetch_req` and `fetch_ready` both high), and `data_valid` is high exactly in the cycle after `data_grant`.
- R10: A flash or zero fetch in the same cycle as a data request is accepted without stall, and both requests are answered in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_req | input | 1 | Fetch request |
| fetch_addr | input | 16 | Code-space fetch address |
| fetch_ready | output | 1 | Fetch can be accepted this cycle |
| bank_sel | input | BANK_W | Flash bank shown in the high half |
| overlay_en | input | 1 | Map SRAM at the bottom of the high half |
| fetch_valid | output | 1 | Fetch response valid |
| fetch_target | output | 2 | 0 flash, 1 SRAM, 2 zero |
| fetch_phys_addr | output | BANK_W+15 | Physical address used |
| fetch_rdata | output | DATA_W | Fetched byte |
| flash_rd_en | output | 1 | Flash read strobe |
| flash_rd_addr | output | BANK_W+15 | Flash read address |
| flash_rd_data | input | DATA_W | Flash data, one cycle after strobe |
| data_req | input | 1 | Data-side SRAM read request |
| data_addr | input | SRAM_AW | Data-side SRAM address |
| data_grant | output | 1 | Data request taken this cycle |
| data_valid | output | 1 | Data-side response valid |
| data_rdata | output | DATA_W | Data-side byte |
| sram_en | output | 1 | SRAM read strobe |
| sram_addr | output | SRAM_AW | SRAM read address |
| sram_rd_data | input | DATA_W | SRAM data, one cycle after strobe |

## Verification
A wrong decode shows up in the very next cycle as a wrong `fetch_target` or `fetch_phys_addr` beside `fetch_valid`. The bench sweeps every bank value and both overlay settings across the window edges, on a four-bank and a one-bank instance, so a bad bank compare or an off-by-one window is caught at once. A stuck or lost stall flag shows as `fetch_ready` staying low for a second cycle, or as a data grant in the fetch's retry cycle. A mis-registered target shows as SRAM or zero bytes where flash bytes were expected one cycle after the request.

// File: rtl/cbm_pkg.sv
package cbm_pkg;
  typedef enum logic [1:0] {
    TGT_FLASH = 2'd0,
    TGT_SRAM  = 2'd1,
    TGT_ZERO  = 2'd2
  } tgt_e;
endpackage

// File: rtl/cbm_decode.sv
module cbm_decode
  import cbm_pkg::*;
#(
  parameter int BANK_W     = 3,
  parameter int NUM_BANKS  = 4,
  parameter int SRAM_BYTES = 1024,
  parameter int PA_W       = BANK_W + 15
) (
  input  logic [15:0]       addr,
  input  logic [BANK_W-1:0] bank,
  input  logic              ovl,
  output tgt_e              tgt,
  output logic [PA_W-1:0]   phys,
  output logic              bank_ok,
  output logic              in_window
);
  localparam logic [31:0] WIN_LIM = 32'(SRAM_BYTES);

  logic [14:0] ofs;
  assign ofs = addr[14:0];

  // R3: a single-bank device has no banked flash at all
  generate
    if (NUM_BANKS <= 1) begin : g_one_bank
      assign bank_ok = 1'b0;
    end else begin : g_multi_bank
      localparam logic [BANK_W:0] NB = (BANK_W+1)'(NUM_BANKS);
      assign bank_ok = ({1'b0, bank} < NB);
    end
  endgenerate

  assign in_window = addr[15] && ovl && ({17'd0, ofs} < WIN_LIM);

  always_comb begin
    if (!addr[15]) begin
      tgt  = TGT_FLASH;
      phys = PA_W'(ofs);
    end else if (in_window) begin
      tgt  = TGT_SRAM;
      phys = PA_W'(ofs);
    end else if (bank_ok) begin
      tgt  = TGT_FLASH;
      phys = {bank, ofs};
    end else begin
      tgt  = TGT_ZERO;
      phys = '0;
    end
  end
endmodule

// File: rtl/cbm_sram_arb.sv
module cbm_sram_arb #(
  parameter int SRAM_AW = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fetch_sram,
  input  logic [SRAM_AW-1:0] fetch_ofs,
  input  logic               data_req,
  input  logic [SRAM_AW-1:0] data_addr,
  output logic               fetch_block,
  output logic               data_grant,
  output logic               sram_en,
  output logic [SRAM_AW-1:0] sram_addr,
  output logic               stall_q
);
  logic collide;

  assign collide     = fetch_sram && data_req;
  assign fetch_block = collide && !stall_q;
  assign data_grant  = data_req && !(fetch_sram && stall_q);
  assign sram_en     = data_grant || (fetch_sram && !fetch_block);
  assign sram_addr   = data_grant ? data_addr : fetch_ofs;

  // one-cycle memory of a lost fetch, giving it priority next cycle
  always_ff @(posedge clk) begin
    if (!rst_n) stall_q <= 1'b0;
    else        stall_q <= fetch_block;
  end
endmodule

// File: rtl/cbm_resp.sv
module cbm_resp
  import cbm_pkg::*;
#(
  parameter int PA_W   = 18,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  tgt_e              tgt_in,
  input  logic [PA_W-1:0]   phys_in,
  input  logic              data_grant,
  input  logic [DATA_W-1:0] flash_rd_data,
  input  logic [DATA_W-1:0] sram_rd_data,
  output logic              fetch_valid,
  output tgt_e              tgt_q,
  output logic [PA_W-1:0]   phys_q,
  output logic [DATA_W-1:0] fetch_rdata,
  output logic              data_valid,
  output logic [DATA_W-1:0] data_rdata
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fetch_valid <= 1'b0;
      tgt_q       <= TGT_ZERO;
      phys_q      <= '0;
      data_valid  <= 1'b0;
    end else begin
      fetch_valid <= accept;
      data_valid  <= data_grant;
      if (accept) begin
        tgt_q  <= tgt_in;
        phys_q <= phys_in;
      end
    end
  end

  always_comb begin
    case (tgt_q)
      TGT_FLASH: fetch_rdata = flash_rd_data;
      TGT_SRAM:  fetch_rdata = sram_rd_data;
      default:   fetch_rdata = '0;
    endcase
  end

  assign data_rdata = sram_rd_data;
endmodule

// File: rtl/code_bank_mapper.sv
module code_bank_mapper
  import cbm_pkg::*;
#(
  parameter int BANK_W     = 3,
  parameter int NUM_BANKS  = 4,
  parameter int SRAM_BYTES = 1024,
  parameter int DATA_W     = 8,
  localparam int PA_W      = BANK_W + 15,
  localparam int SRAM_AW   = $clog2(SRAM_BYTES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fetch_req,
  input  logic [15:0]        fetch_addr,
  output logic               fetch_ready,
  input  logic [BANK_W-1:0]  bank_sel,
  input  logic               overlay_en,
  output logic               fetch_valid,
  output logic [1:0]         fetch_target,
  output logic [PA_W-1:0]    fetch_phys_addr,
  output logic [DATA_W-1:0]  fetch_rdata,
  output logic               flash_rd_en,
  output logic [PA_W-1:0]    flash_rd_addr,
  input  logic [DATA_W-1:0]  flash_rd_data,
  input  logic               data_req,
  input  logic [SRAM_AW-1:0] data_addr,
  output logic               data_grant,
  output logic               data_valid,
  output logic [DATA_W-1:0]  data_rdata,
  output logic               sram_en,
  output logic [SRAM_AW-1:0] sram_addr,
  input  logic [DATA_W-1:0]  sram_rd_data
);
  tgt_e            dec_tgt;
  logic [PA_W-1:0] dec_phys;
  logic            bank_ok;
  logic            in_window;
  logic            fetch_sram;
  logic            fetch_block;
  logic            stall_q;
  logic            accept;
  tgt_e            tgt_q;

  cbm_decode #(
    .BANK_W(BANK_W), .NUM_BANKS(NUM_BANKS),
    .SRAM_BYTES(SRAM_BYTES), .PA_W(PA_W)
  ) u_decode (
    .addr(fetch_addr), .bank(bank_sel), .ovl(overlay_en),
    .tgt(dec_tgt), .phys(dec_phys), .bank_ok(bank_ok), .in_window(in_window)
  );

  assign fetch_sram = fetch_req && (dec_tgt == TGT_SRAM);

  cbm_sram_arb #(.SRAM_AW(SRAM_AW)) u_arb (
    .clk(clk), .rst_n(rst_n),
    .fetch_sram(fetch_sram), .fetch_ofs(dec_phys[SRAM_AW-1:0]),
    .data_req(data_req), .data_addr(data_addr),
    .fetch_block(fetch_block), .data_grant(data_grant),
    .sram_en(sram_en), .sram_addr(sram_addr), .stall_q(stall_q)
  );

  assign fetch_ready   = !fetch_block;
  assign accept        = fetch_req && fetch_ready;
  assign flash_rd_en   = accept && (dec_tgt == TGT_FLASH);
  assign flash_rd_addr = dec_phys;

  cbm_resp #(.PA_W(PA_W), .DATA_W(DATA_W)) u_resp (
    .clk(clk), .rst_n(rst_n),
    .accept(accept), .tgt_in(dec_tgt), .phys_in(dec_phys),
    .data_grant(data_grant),
    .flash_rd_data(flash_rd_data), .sram_rd_data(sram_rd_data),
    .fetch_valid(fetch_valid), .tgt_q(tgt_q), .phys_q(fetch_phys_addr),
    .fetch_rdata(fetch_rdata),
    .data_valid(data_valid), .data_rdata(data_rdata)
  );

  assign fetch_target = tgt_q;
endmodule

// File: rtl/cbm_checker.sv
module cbm_checker #(
  parameter int PA_W   = 18,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fetch_req,
  input logic [15:0]       fetch_addr,
  input logic              fetch_ready,
  input logic              fetch_valid,
  input logic [1:0]        fetch_target,
  input logic [PA_W-1:0]   fetch_phys_addr,
  input logic [DATA_W-1:0] fetch_rdata,
  input logic              data_req,
  input logic              data_grant,
  input logic              data_valid,
  input logic              accept,
  input logic [1:0]        dec_tgt
);
  assert_resp_next_R9: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> fetch_valid);
  assert_no_spurious_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> !fetch_valid);
  assert_data_next_R9: assert property (@(posedge clk) disable iff (!rst_n)
    data_grant |=> data_valid);
  assert_zero_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && fetch_target == 2'd2) |-> (fetch_rdata == '0 && fetch_phys_addr == '0));
  assert_low_half_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !fetch_addr[15]) |=>
      (fetch_target == 2'd0 && fetch_phys_addr == PA_W'($past(fetch_addr[14:0]))));
  assert_stall_once_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req && !fetch_ready) |=> fetch_ready);
  assert_stall_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_ready |-> data_req);
  assert_port_shared_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (data_grant && accept) |-> (dec_tgt != 2'd1));
endmodule

bind code_bank_mapper cbm_checker #(.PA_W(PA_W), .DATA_W(DATA_W)) u_cbm_checker (
  .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
  .fetch_ready(fetch_ready), .fetch_valid(fetch_valid), .fetch_target(fetch_target),
  .fetch_phys_addr(fetch_phys_addr), .fetch_rdata(fetch_rdata),
  .data_req(data_req), .data_grant(data_grant), .data_valid(data_valid),
  .accept(accept), .dec_tgt(dec_tgt)
);

// File: tb/code_bank_mapper_bench.sv
`timescale 1ns/1ps
module code_bank_mapper_bench;
  localparam int SRAM = 1024;
  localparam int NB   = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        fetch_req = 1'b0;
  logic [15:0] fetch_addr = '0;
  logic [2:0]  bank_sel = '0;
  logic        overlay_en = 1'b0;
  logic        data_req = 1'b0;
  logic [9:0]  data_addr = '0;

  // four-bank instance
  logic        f_ready, f_valid, fl_en, d_grant, d_valid, s_en;
  logic [1:0]  f_tgt;
  logic [17:0] f_phys, fl_addr;
  logic [7:0]  f_data, d_data, fl_q, s_q;
  logic [9:0]  s_addr;
  // single-bank instance
  logic        o_ready, o_valid, ofl_en, o_grant, o_dvalid, os_en;
  logic [1:0]  o_tgt;
  logic [17:0] o_phys, ofl_addr;
  logic [7:0]  o_data, o_ddata, ofl_q, os_q;
  logic [9:0]  os_addr;

  function automatic logic [7:0] flash_byte(input logic [17:0] a);
    return a[7:0] ^ {1'b0, a[14:8]} ^ ({5'd0, a[17:15]} * 8'd41) ^ 8'h5A;
  endfunction
  function automatic logic [7:0] sram_byte(input logic [9:0] a);
    return a[7:0] ^ {a[9:8], 6'd0} ^ 8'hC3;
  endfunction

  code_bank_mapper #(.NUM_BANKS(NB), .SRAM_BYTES(SRAM)) u_code_bank_mapper (
    .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
    .fetch_ready(f_ready), .bank_sel(bank_sel), .overlay_en(overlay_en),
    .fetch_valid(f_valid), .fetch_target(f_tgt), .fetch_phys_addr(f_phys),
    .fetch_rdata(f_data), .flash_rd_en(fl_en), .flash_rd_addr(fl_addr),
    .flash_rd_data(fl_q), .data_req(data_req), .data_addr(data_addr),
    .data_grant(d_grant), .data_valid(d_valid), .data_rdata(d_data),
    .sram_en(s_en), .sram_addr(s_addr), .sram_rd_data(s_q));

  code_bank_mapper #(.NUM_BANKS(1), .SRAM_BYTES(SRAM)) u_code_bank_mapper_one (
    .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
    .fetch_ready(o_ready), .bank_sel(bank_sel), .overlay_en(overlay_en),
    .fetch_valid(o_valid), .fetch_target(o_tgt), .fetch_phys_addr(o_phys),
    .fetch_rdata(o_data), .flash_rd_en(ofl_en), .flash_rd_addr(ofl_addr),
    .flash_rd_data(ofl_q), .data_req(data_req), .data_addr(data_addr),
    .data_grant(o_grant), .data_valid(o_dvalid), .data_rdata(o_ddata),
    .sram_en(os_en), .sram_addr(os_addr), .sram_rd_data(os_q));

  // memory models with one cycle of read latency
  always @(posedge clk) begin
    if (fl_en)  fl_q  <= flash_byte(fl_addr);
    if (s_en)   s_q   <= sram_byte(s_addr);
    if (ofl_en) ofl_q <= flash_byte(ofl_addr);
    if (os_en)  os_q  <= sram_byte(os_addr);
  end

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // expected mapping from the requirements
  task automatic expect_map(input logic [15:0] a, input logic [2:0] b, input logic ov,
                            input int nb, output logic [1:0] t, output logic [17:0] p,
                            output logic [7:0] d);
    int ofs;
    ofs = int'(a) - 32768;
    if (a < 16'h8000) begin
      t = 2'd0; p = 18'(a);
    end else if (ov && ofs < SRAM) begin
      t = 2'd1; p = 18'(ofs);
    end else if (nb > 1 && int'(b) < nb) begin
      t = 2'd0; p = 18'(int'(b) * 32768 + ofs);
    end else begin
      t = 2'd2; p = '0;
    end
    case (t)
      2'd0:    d = flash_byte(p);
      2'd1:    d = sram_byte(p[9:0]);
      default: d = 8'h00;
    endcase
  endtask

  function automatic string tag_of(input logic [15:0] a, input logic ov, input logic [1:0] t);
    if (!a[15])        return "R1";
    if (t == 2'd1)     return "R4";
    if (t == 2'd2)     return "R3";
    if (ov)            return "R5";
    return "R2";
  endfunction

  task automatic do_fetch(input logic [15:0] a, input logic [2:0] b, input logic ov,
                          input string force_tag);
    logic [1:0] t; logic [17:0] p; logic [7:0] d; string tg;
    @(negedge clk);
    bank_sel = b; overlay_en = ov; fetch_req = 1'b1; fetch_addr = a;
    @(negedge clk);
    fetch_req = 1'b0;
    expect_map(a, b, ov, NB, t, p, d);
    tg = (force_tag != "") ? force_tag : tag_of(a, ov, t);
    chk({tg, " R9 valid"}, 32'(f_valid), 32'd1);
    chk({tg, " target"}, 32'(f_tgt), 32'(t));
    chk({tg, " phys"}, 32'(f_phys), 32'(p));
    chk({tg, " data"}, 32'(f_data), 32'(d));
    expect_map(a, b, ov, 1, t, p, d);
    tg = (force_tag != "") ? force_tag : tag_of(a, ov, t);
    chk({tg, " one-bank target"}, 32'(o_tgt), 32'(t));
    chk({tg, " one-bank phys"}, 32'(o_phys), 32'(p));
    chk({tg, " one-bank data"}, 32'(o_data), 32'(d));
  endtask

  initial begin : watchdog
    #(5.0 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic [15:0] edges [6];
    edges[0] = 16'h0000; edges[1] = 16'h7FFF; edges[2] = 16'h8000;
    edges[3] = 16'(32768 + SRAM - 1); edges[4] = 16'(32768 + SRAM); edges[5] = 16'hFFFF;

    repeat (3) @(negedge clk);
    // R6: reset state
    chk("R6 fetch_valid in reset", 32'(f_valid), 32'd0);
    chk("R6 data_valid in reset", 32'(d_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R6 fetch_valid after reset", 32'(f_valid), 32'd0);
    chk("R6 data_valid after reset", 32'(d_valid), 32'd0);
    chk("R6 fetch_ready after reset", 32'(f_ready), 32'd1);
    // R6: first fetch at 0x0000 reads flash 0
    do_fetch(16'h0000, 3'd5, 1'b1, "R6");
    @(negedge clk);
    chk("R9 valid drops", 32'(f_valid), 32'd0);
    chk("R3 no flash read on zero target", 32'(fl_en), 32'd0);

    // sweep all bank values and both overlay settings
    for (int ov = 0; ov < 2; ov++) begin
      for (int b = 0; b < 8; b++) begin
        for (int e = 0; e < 6; e++) do_fetch(edges[e], 3'(b), ov[0], "");
        for (int a = 0; a < 65536; a += 499) do_fetch(16'(a), 3'(b), ov[0], "");
      end
    end

    // R3: zero target raises no flash strobe
    @(negedge clk);
    bank_sel = 3'd6; overlay_en = 1'b0; fetch_req = 1'b1; fetch_addr = 16'hA000;
    #1 chk("R3 flash_rd_en on unavailable bank", 32'(fl_en), 32'd0);
    @(negedge clk);
    fetch_req = 1'b0;

    // R7: config change after acceptance has no effect
    @(negedge clk);
    bank_sel = 3'd1; overlay_en = 1'b0; fetch_req = 1'b1; fetch_addr = 16'h8123;
    @(negedge clk);
    fetch_req = 1'b0; bank_sel = 3'd3; overlay_en = 1'b1;
    #1;
    chk("R7 target held", 32'(f_tgt), 32'd0);
    chk("R7 phys held", 32'(f_phys), 32'h08123);
    chk("R7 data held", 32'(f_data), 32'(flash_byte(18'h08123)));

    // R10: flash fetch and data request together
    @(negedge clk);
    bank_sel = 3'd1; overlay_en = 1'b1; fetch_req = 1'b1; fetch_addr = 16'h9000;
    data_req = 1'b1; data_addr = 10'd7;
    #1;
    chk("R10 fetch_ready", 32'(f_ready), 32'd1);
    chk("R10 data_grant", 32'(d_grant), 32'd1);
    @(negedge clk);
    fetch_req = 1'b0; data_req = 1'b0;
    chk("R10 fetch_valid", 32'(f_valid), 32'd1);
    chk("R10 fetch data", 32'(f_data), 32'(flash_byte(18'h09000)));
    chk("R10 data_valid", 32'(d_valid), 32'd1);
    chk("R10 data byte", 32'(d_data), 32'(sram_byte(10'd7)));

    // R8: collision on the SRAM port
    @(negedge clk);
    overlay_en = 1'b1; fetch_req = 1'b1; fetch_addr = 16'h8010;
    data_req = 1'b1; data_addr = 10'd5;
    #1;
    chk("R8 fetch stalled", 32'(f_ready), 32'd0);
    chk("R8 data granted", 32'(d_grant), 32'd1);
    @(negedge clk);
    chk("R8 data_valid", 32'(d_valid), 32'd1);
    chk("R8 data byte", 32'(d_data), 32'(sram_byte(10'd5)));
    chk("R8 no fetch response yet", 32'(f_valid), 32'd0);
    #1;
    chk("R8 fetch wins retry", 32'(f_ready), 32'd1);
    chk("R8 data waits", 32'(d_grant), 32'd0);
    @(negedge clk);
    fetch_req = 1'b0;
    chk("R8 fetch valid after retry", 32'(f_valid), 32'd1);
    chk("R8 fetch target", 32'(f_tgt), 32'd1);
    chk("R8 fetch byte", 32'(f_data), 32'(sram_byte(10'h010)));
    chk("R8 no data response", 32'(d_valid), 32'd0);
    #1 chk("R8 data granted again", 32'(d_grant), 32'd1);
    @(negedge clk);
    data_req = 1'b0;
    chk("R9 data_valid after grant", 32'(d_valid), 32'd1);
    @(negedge clk);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule